// File: doc/BRIEF.md
# UART Receiver with Idle-Line Detection

This block is the receive half of an asynchronous serial port. It watches a serial line at sixteen samples per bit and turns each character into a parallel word. A character is a start bit, then 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one stop bit. Each word comes out with a one-cycle valid strobe and two flags. One flag reports a parity mismatch and the other reports a bad stop bit. A baud generator outside the block supplies the sampling tick. A clock-enable input freezes the whole receiver.

Alongside the character path, the block counts bit times of logic 1 on the line and reports an idle character. The point at which counting starts can be chosen. In one setting the count starts right after the start bit, so data 1s count toward idle. In the other setting the count starts only after the stop bit.

The block also has a wakeup mode. When wakeup is switched on, the receiver goes to sleep and drops every character until it sees an idle line. The idle line then wakes it, and the next character is delivered.

Top module: `uart_idle_rx`

## Requirements
- R1: A start bit is accepted only when at least two of the three samples at ticks 7, 8 and 9 of the bit are 0. A low pulse that fails this vote returns the receiver to hunting and produces no character.
- R2: Data bits are taken least significant bit first. There are 9 of them when `cfg_nine` is 1 and 8 otherwise. In 8-bit mode `rx_data[8]` is 0. Each character raises `rx_valid` for exactly one clock cycle.
- R3: When `cfg_par_en` is 1, the bit just before the stop bit is parity. With `cfg_par_odd`=0 the expected parity bit is the XOR of the data bits. With `cfg_par_odd`=1 it is the inverse of that XOR. `rx_perr` is 1 on a mismatch. With parity off, `rx_perr` is 0.
- R4: `rx_ferr` is 1 when the stop bit is voted 0, and the data is still delivered. `rx_data`, `rx_perr` and `rx_ferr` change only together with `rx_valid` and hold their values between characters.
- R5: The idle threshold is counted in bit times of 1. It is 10 for 8 data bits without parity. It is 11 for 9 data bits without parity or for 8 data bits with parity. It is 12 for 9 data bits with parity.
- R6: With `cfg_idle_after_stop`=0, the count restarts at a confirmed start bit, and every data, parity or stop bit voted 1 adds to it.
- R7: With `cfg_idle_after_stop`=1, every bit inside a character, the stop bit included, resets the count to 0. Only 1s after the stop bit add to it.
- R8: `rx_idle` pulses for one cycle when the count reaches the threshold. It does not pulse again until a character has been received. The receiver comes out of reset armed for one pulse.
- R9: A rising edge on `cfg_wake_en` puts the receiver to sleep and clears the idle count. While asleep, no `rx_valid` is produced and the outputs hold. Idle counting follows the R6 rule whatever `cfg_idle_after_stop` is set to. An idle pulse ends sleep, and the next character is delivered.
- R10: While `en` is 0 the receiver state does not advance, and a character sent on the line during that time is not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the whole receiver |
| baud_tick | input | 1 | One pulse per oversampling period (16 per bit) |
| rxd | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_idle_after_stop | input | 1 | 1 starts idle counting after the stop bit, 0 after the start bit |
| cfg_wake_en | input | 1 | Rising edge enters idle-line wakeup sleep; 0 leaves it |
| rx_data | output | 9 | Received character, zero-extended in 8-bit mode |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| rx_perr | output | 1 | Parity mismatch for the last delivered character |
| rx_ferr | output | 1 | Stop bit read as 0 for the last delivered character |
| rx_idle | output | 1 | One-cycle idle-character pulse |

## Verification
The assertions assume a few things about the inputs:
- The configuration bits stay constant for the whole of a character and for the whole idle gap being measured.
- The baud tick arrives often enough that a character covers many clock cycles, so two valid strobes or two idle pulses can never fall in adjacent cycles.

The stimulus keeps to these rules. It changes configuration only while the line is idle. It holds each bit for sixteen ticks. It places every idle-count check at least several ticks away from the expected threshold crossing, so the synchronizer delay and the tick phase cannot shift a result.

// File: rtl/uirx_pkg.sv
package uirx_pkg;

    localparam int OVS  = 16;
    localparam int CW   = $clog2(OVS);
    localparam int DMAX = 9;
    localparam int BW   = $clog2(DMAX + 1);
    localparam int IW   = 4;

    localparam int SMP_FIRST = OVS / 2 - 1;
    localparam int SMP_DEC   = OVS / 2 + 1;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } char_cfg_t;

    typedef struct packed {
        logic start_ok;
        logic bit_evt;
        logic bit_val;
        logic hunt_one;
        logic done;
    } line_evt_t;

    typedef struct packed {
        logic [DMAX-1:0] data;
        logic            perr;
        logic            ferr;
    } char_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par_of(input logic [DMAX-1:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

    // Idle threshold equals the number of bit times in one character.
    function automatic logic [IW-1:0] idle_thr(input char_cfg_t c);
        return IW'(DMAX + 1) + IW'(c.nine) + IW'(c.par_en);
    endfunction

endpackage

// File: rtl/uirx_sync.sv
module uirx_sync (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b1;
            dout <= 1'b1;
        end else if (en) begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/uirx_framer.sv
module uirx_framer
    import uirx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tk,
    input  logic      rx,
    input  char_cfg_t cfg,
    output line_evt_t evt,
    output char_t     chr
);
    rx_state_e       st;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   idx;
    logic [1:0]      smp;
    logic [DMAX-1:0] shreg;
    logic            parbit;

    logic            vote, at_dec, at_end, in_win;
    logic [BW-1:0]   last_idx;
    logic [CW-1:0]   cnt_inc;
    logic [DMAX-1:0] data_al;

    always_comb begin
        vote     = maj3(smp[1], smp[0], rx);
        at_dec   = (cnt == CW'(SMP_DEC));
        at_end   = (cnt == CW'(OVS - 1));
        in_win   = (cnt >= CW'(SMP_FIRST)) && (cnt <= CW'(SMP_DEC));
        cnt_inc  = at_end ? '0 : cnt + 1'b1;
        last_idx = cfg.nine ? BW'(DMAX - 1) : BW'(DMAX - 2);
        data_al  = cfg.nine ? shreg : (shreg >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT;
            cnt    <= '0;
            idx    <= '0;
            smp    <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
        end else if (tk) begin
            if (st != ST_HUNT && in_win)
                smp <= {smp[0], rx};
            unique case (st)
                ST_HUNT: begin
                    if (!rx) begin
                        st  <= ST_START;
                        cnt <= CW'(1);
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                ST_START: begin
                    cnt <= cnt_inc;
                    if (at_dec && vote) begin
                        st  <= ST_HUNT;
                        cnt <= '0;
                    end else if (at_end) begin
                        st  <= ST_DATA;
                        idx <= '0;
                    end
                end
                ST_DATA: begin
                    cnt <= cnt_inc;
                    if (at_dec)
                        shreg <= {vote, shreg[DMAX-1:1]};
                    if (at_end) begin
                        if (idx == last_idx)
                            st <= cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    cnt <= cnt_inc;
                    if (at_dec)
                        parbit <= vote;
                    if (at_end)
                        st <= ST_STOP;
                end
                ST_STOP: begin
                    cnt <= cnt_inc;
                    if (at_dec) begin
                        st  <= ST_HUNT;
                        cnt <= '0;
                    end
                end
                default: st <= ST_HUNT;
            endcase
        end
    end

    always_comb begin
        evt.start_ok = tk && (st == ST_START) && at_dec && !vote;
        evt.bit_evt  = tk && at_dec &&
                       (st == ST_DATA || st == ST_PAR || st == ST_STOP);
        evt.bit_val  = vote;
        evt.hunt_one = tk && (st == ST_HUNT) && rx && at_end;
        evt.done     = tk && (st == ST_STOP) && at_dec;
        chr.data     = data_al;
        chr.perr     = cfg.par_en && (parbit != par_of(data_al, cfg.par_odd));
        chr.ferr     = !vote;
    end

    // R1: a confirmed start must come out of the start-check state
    assert_start_from_check_R1: assert property (@(posedge clk) disable iff (rst)
        evt.start_ok |=> (st == ST_START || st == ST_DATA));
endmodule

// File: rtl/uirx_idle.sv
module uirx_idle
    import uirx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  line_evt_t     evt,
    input  logic [IW-1:0] thr,
    input  logic          after_stop,
    input  logic          asleep,
    input  logic          clear,
    output logic          idle_pulse
);
    logic [IW-1:0] run, run_nxt;
    logic          armed, fire, ones_up;

    always_comb begin
        ones_up = 1'b0;
        run_nxt = run;
        if (clear || evt.start_ok) begin
            run_nxt = '0;
        end else if (evt.bit_evt) begin
            if (!evt.bit_val || (after_stop && !asleep))
                run_nxt = '0;
            else
                ones_up = 1'b1;
        end else if (evt.hunt_one) begin
            ones_up = 1'b1;
        end
        if (ones_up)
            run_nxt = (run >= thr) ? run : run + 1'b1;
        fire = ones_up && (run_nxt == thr) && (run != thr) && (armed || asleep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run        <= '0;
            armed      <= 1'b1;
            idle_pulse <= 1'b0;
        end else begin
            run        <= run_nxt;
            idle_pulse <= fire;
            if (evt.done)
                armed <= 1'b1;
            else if (fire)
                armed <= 1'b0;
        end
    end

    // R8: idle is a single-cycle pulse
    assert_idle_single_R8: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse);

    // R6: the framer never issues two counting events in one cycle
    assert_evt_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.start_ok, evt.bit_evt, evt.hunt_one}));
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
    import uirx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            baud_tick,
    input  logic            rxd,
    input  logic            cfg_nine,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            cfg_idle_after_stop,
    input  logic            cfg_wake_en,
    output logic [DMAX-1:0] rx_data,
    output logic            rx_valid,
    output logic            rx_perr,
    output logic            rx_ferr,
    output logic            rx_idle
);
    char_cfg_t cfg;
    line_evt_t evt;
    char_t     chr;
    logic      rx_s, tk, wake_q, wake_rise, asleep;

    assign cfg       = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};
    assign tk        = en && baud_tick;
    assign wake_rise = cfg_wake_en && !wake_q;

    uirx_sync u_sync (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .din (rxd),
        .dout(rx_s)
    );

    uirx_framer u_framer (
        .clk(clk),
        .rst(rst),
        .tk (tk),
        .rx (rx_s),
        .cfg(cfg),
        .evt(evt),
        .chr(chr)
    );

    uirx_idle u_idle (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .thr       (idle_thr(cfg)),
        .after_stop(cfg_idle_after_stop),
        .asleep    (asleep),
        .clear     (wake_rise),
        .idle_pulse(rx_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q   <= 1'b0;
            asleep   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            wake_q   <= cfg_wake_en;
            rx_valid <= evt.done && !asleep;
            if (evt.done && !asleep) begin
                rx_data <= chr.data;
                rx_perr <= chr.perr;
                rx_ferr <= chr.ferr;
            end
            if (wake_rise)
                asleep <= 1'b1;
            else if (!cfg_wake_en || rx_idle)
                asleep <= 1'b0;
        end
    end

    // R9: no character is delivered while asleep
    assert_no_valid_asleep_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !$past(asleep));

    // R2: valid is a single-cycle strobe
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: flags and data hold between delivered characters
    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_ferr) && $stable(rx_perr) && $stable(rx_data)));
endmodule

// File: tb/uart_idle_rx_test.sv
module uart_idle_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int BITCLK     = 32;  // 16 ticks, one tick every 2 clocks
    localparam int NVEC       = 8;

    // {bad_stop, bad_par, par_odd, par_en, nine, data[8:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {5'b00000, 9'h0A5},
        {5'b00010, 9'h0FF},
        {5'b00110, 9'h03C},
        {5'b00001, 9'h1A5},
        {5'b01011, 9'h155},
        {5'b01110, 9'h081},
        {5'b10000, 9'h000},
        {5'b00111, 9'h1FF}
    };

    logic clk = 1'b0, rst = 1'b1, en = 1'b1, tick = 1'b0, rxd = 1'b1;
    logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic cfg_idle_after_stop = 1'b0, cfg_wake_en = 1'b0;
    logic [8:0] rx_data;
    logic rx_valid, rx_perr, rx_ferr, rx_idle;

    int nchk = 0, nfail = 0, nvalid = 0, nidle = 0;
    logic [8:0] last_data = '0;
    logic last_perr = 1'b0, last_ferr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    uart_idle_rx uut (
        .clk(clk), .rst(rst), .en(en), .baud_tick(tick), .rxd(rxd),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_idle_after_stop(cfg_idle_after_stop), .cfg_wake_en(cfg_wake_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_idle(rx_idle)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            nvalid++;
            last_data = rx_data;
            last_perr = rx_perr;
            last_ferr = rx_ferr;
        end
        if (!rst && rx_idle) nidle++;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        @(negedge clk);
        #1;
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (BITCLK - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic nine, input logic pe,
                              input logic podd, input logic bad_par, input logic bad_stop);
        logic [8:0] dm;
        logic p;
        dm = nine ? d : {1'b0, d[7:0]};
        p  = podd ? ~(^dm) : (^dm);
        send_bit(1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) send_bit(dm[i]);
        if (pe) send_bit(p ^ bad_par);
        send_bit(!bad_stop);
        @(negedge clk);
        rxd = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int v0, n0;
        logic [8:0] ed;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R2", "reset outputs", {rx_valid, rx_perr, rx_ferr, rx_idle, rx_data},
              32'h0);

        // R8: armed at reset, one idle pulse only
        wait_bits(12);
        check("R8", "idle after reset", nidle, 1);
        wait_bits(12);
        check("R8", "no refire without character", nidle, 1);

        // Table of characters (R2 R3 R4)
        for (int k = 0; k < NVEC; k++) begin
            cfg_nine   = VEC[k][9];
            cfg_par_en = VEC[k][10];
            cfg_par_odd = VEC[k][11];
            v0 = nvalid;
            send_frame(VEC[k][8:0], VEC[k][9], VEC[k][10], VEC[k][11],
                       VEC[k][12], VEC[k][13]);
            wait_bits(2);
            ed = VEC[k][9] ? VEC[k][8:0] : {1'b0, VEC[k][7:0]};
            check("R2", "one valid per character", nvalid, v0 + 1);
            check("R3_R4", "data/perr/ferr", {last_data, last_perr, last_ferr},
                  {ed, VEC[k][12] & VEC[k][10], VEC[k][13]});
        end
        cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;

        // R1: short low glitch rejected
        v0 = nvalid;
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wait_bits(3);
        check("R1", "false start gives no character", nvalid, v0);
        send_frame(9'h07E, 0, 0, 0, 0, 0);
        wait_bits(2);
        check("R1", "character after false start", last_data, 9'h07E);

        // R10: frozen while enable low
        v0 = nvalid;
        en = 1'b0;
        send_frame(9'h033, 0, 0, 0, 0, 0);
        wait_bits(2);
        en = 1'b1;
        wait_bits(3);
        check("R10", "no character with enable low", nvalid, v0);

        // R6: count starts after start bit
        cfg_idle_after_stop = 0;
        wait_bits(14);
        send_frame(9'h0FF, 0, 0, 0, 0, 0);
        n0 = nidle;
        wait_bits(3);
        check("R6", "data ones count toward idle", nidle, n0 + 1);

        // R7 / R5 threshold 10
        cfg_idle_after_stop = 1;
        wait_bits(14);
        send_frame(9'h0FF, 0, 0, 0, 0, 0);
        n0 = nidle;
        wait_bits(3);
        check("R7", "no early idle after stop", nidle, n0);
        wait_bits(8);
        check("R7_R5", "idle after 10 ones past stop", nidle, n0 + 1);

        // R5 threshold 12 (9 data + parity)
        cfg_nine = 1; cfg_par_en = 1;
        wait_bits(2);
        send_frame(9'h1FF, 1, 1, 0, 0, 0);
        n0 = nidle;
        wait_bits(11);
        check("R5", "no idle before 12", nidle, n0);
        wait_bits(2);
        check("R5", "idle at 12", nidle, n0 + 1);

        // R5 threshold 11 (8 data + parity)
        cfg_nine = 0;
        wait_bits(2);
        send_frame(9'h0FF, 0, 1, 0, 0, 0);
        n0 = nidle;
        wait_bits(10);
        check("R5", "no idle before 11", nidle, n0);
        wait_bits(2);
        check("R5", "idle at 11", nidle, n0 + 1);
        wait_bits(15);
        check("R8", "no second idle", nidle, n0 + 1);
        cfg_par_en = 0;

        // R9: wakeup sleep
        wait_bits(2);
        v0 = nvalid;
        @(negedge clk);
        cfg_wake_en = 1'b1;
        send_frame(9'h000, 0, 0, 0, 0, 0);
        send_frame(9'h0FF, 0, 0, 0, 0, 0);
        n0 = nidle;
        check("R9", "no character while asleep", nvalid, v0);
        wait_bits(3);
        check("R9", "idle type ignored while asleep", nidle, n0 + 1);
        send_frame(9'h05A, 0, 0, 0, 0, 0);
        wait_bits(2);
        check("R9", "character after wake", {nvalid, 7'b0, last_data},
              {v0 + 1, 7'b0, 9'h05A});
        cfg_wake_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule